// File: doc/BRIEF.md
# Time-of-Day Alarm Interrupt

This block holds three alarm registers for minutes, hours and day of week, and compares them with the running calendar time. The top bit of each register is a mask bit. Taken together, the three mask bits choose how often the alarm fires: at every minute boundary, when the minutes match, when hours and minutes match, or when minutes, hours and day all match. A match sets a time-of-day flag. Software cannot write the flag. Any read or write of an alarm register clears it.

The flag drives an interrupt request, which can be suppressed by a mask input. A select input can hand the request line to an external watchdog source. In level mode the flag, and so the request, stays high until software clears it. In pulse mode the flag goes high for a fixed number of clock cycles and then drops by itself. The pulse length is set by a clock-rate parameter and a length in milliseconds, which gives 3 ms by default.

The timekeeper drives `tick` once each time the hundredths count rolls from 99 to 00. It drives `min_edge` when the seconds count rolls from 59 to 00. Alarms are evaluated only in a cycle where both strobes are high, against the time fields present in that cycle.

Top module: `tod_alarm_intr`

## Requirements
- R1: After reset, `tod_flag` is 0, `irq` is 0 while `src_sel` is 0, and all three alarm registers read 0.
- R2: `reg_sel` 0 selects the minutes alarm (bit 7 mask, bits 6:0 BCD minutes). `reg_sel` 1 selects the hours alarm (bit 7 mask, bit 6 12-hour select, bit 5 PM or tens-of-hours, bits 4:0 hours). `reg_sel` 2 selects the day alarm (bit 7 mask, bits 2:0 day), and its bits 6:3 always read 0. `reg_sel` 3 reads 0 and ignores writes. `reg_rdata` shows the selected register combinationally, and a write takes effect at the next clock edge.
- R3: An alarm is evaluated only in a cycle with `tick` and `min_edge` both 1. The register values compared are those held before any write in that same cycle. The flag rises at the following clock edge.
- R4: With mask bits (minutes, hours, day) = 1,1,1, every evaluation fires, whatever the time fields hold.
- R5: With mask bits 0,1,1, an evaluation fires only when `cur_min` equals the minutes alarm bits 6:0.
- R6: With mask bits 0,0,1, minutes and hours must both match. The hours compare covers all seven bits, including the 12-hour select and PM bits.
- R7: With mask bits 0,0,0, minutes, hours and `cur_day` (alarm bits 2:0) must all match.
- R8: Every other mask combination never fires.
- R9: When `pulse_mode` is 0, the flag stays 1 until a read or write with `reg_sel` 0 to 2 clears it. An access with `reg_sel` 3 leaves the flag alone. If an alarm fires in the same cycle as a clearing access, the flag ends up set.
- R10: When `pulse_mode` is 1, an alarm holds the flag at 1 for exactly PULSE_MS ms of clock cycles (CLK_HZ/1000*PULSE_MS), after which it returns to 0. A clearing access ends the pulse early.
- R11: With `src_sel` 0, `irq` equals `tod_flag` AND NOT `tod_mask`. With `src_sel` 1, `irq` follows `wdog_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Hundredths rollover strobe |
| min_edge | input | 1 | Seconds rollover (59 to 00) strobe |
| cur_min | input | 7 | Current BCD minutes |
| cur_hour | input | 7 | Current hours with 12-hour and PM bits |
| cur_day | input | 3 | Current day of week |
| reg_wr | input | 1 | Alarm register write strobe |
| reg_rd | input | 1 | Alarm register read strobe |
| reg_sel | input | 2 | Alarm register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tod_mask | input | 1 | Suppresses the time-of-day request when 1 |
| pulse_mode | input | 1 | 1 selects pulse mode, 0 selects level mode |
| src_sel | input | 1 | 1 routes the watchdog request to `irq` |
| wdog_irq | input | 1 | Watchdog request input |
| tod_flag | output | 1 | Read-only time-of-day flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted alarm register shows up on `reg_rdata` in the same cycle it is selected. A wrong mask decode or compare shows up as a missing or extra rise of `tod_flag` one cycle after a minute boundary. A pulse counter that is off by any amount moves the falling edge of the flag, so the bench measures the pulse length exactly. A flag that clears on the wrong access, or fails to clear, differs at `tod_flag` and `irq` within one cycle. The bench compares every output every cycle against a model, so any of these faults is caught where it first appears.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int REG_W = 8;

    // Register select codes seen on reg_sel
    typedef enum logic [1:0] {
        SEL_MIN  = 2'd0,
        SEL_HOUR = 2'd1,
        SEL_DAY  = 2'd2,
        SEL_NONE = 2'd3
    } alarm_sel_e;

    // Mask bit triple {minutes, hours, day}
    typedef enum logic [2:0] {
        RATE_EVERY_MIN = 3'b111,
        RATE_MIN_HIT   = 3'b011,
        RATE_HM_HIT    = 3'b001,
        RATE_FULL_HIT  = 3'b000
    } alarm_rate_e;

    typedef struct packed {
        logic [REG_W-1:0] min_r;
        logic [REG_W-1:0] hour_r;
        logic [REG_W-1:0] day_r;
    } alarm_bank_t;

    // Bits kept in a register: the value field plus the mask bit on top
    function automatic logic [REG_W-1:0] keep_bits(input int width);
        logic [REG_W-1:0] k;
        for (int i = 0; i < REG_W; i++) begin
            k[i] = (i < width) || (i == REG_W - 1);
        end
        return k;
    endfunction

endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 7,
    parameter int DAY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              access,
    output logic [2:0]        mask_bits,
    output logic [MIN_W-1:0]  alm_min,
    output logic [HOUR_W-1:0] alm_hour,
    output logic [DAY_W-1:0]  alm_day
);

    localparam logic [REG_W-1:0] MIN_KEEP  = keep_bits(MIN_W);
    localparam logic [REG_W-1:0] HOUR_KEEP = keep_bits(HOUR_W);
    localparam logic [REG_W-1:0] DAY_KEEP  = keep_bits(DAY_W);

    alarm_bank_t bank_d, bank_q;
    alarm_sel_e  sel_e;

    assign sel_e = alarm_sel_e'(sel);

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (sel_e)
                SEL_MIN:  bank_d.min_r  = wdata & MIN_KEEP;
                SEL_HOUR: bank_d.hour_r = wdata & HOUR_KEEP;
                SEL_DAY:  bank_d.day_r  = wdata & DAY_KEEP;
                default:  bank_d = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        case (sel_e)
            SEL_MIN:  rdata = bank_q.min_r;
            SEL_HOUR: rdata = bank_q.hour_r;
            SEL_DAY:  rdata = bank_q.day_r;
            default:  rdata = '0;
        endcase
    end

    assign access    = (wr_en | rd_en) & (sel_e != SEL_NONE);
    assign mask_bits = {bank_q.min_r[REG_W-1], bank_q.hour_r[REG_W-1], bank_q.day_r[REG_W-1]};
    assign alm_min   = bank_q.min_r[MIN_W-1:0];
    assign alm_hour  = bank_q.hour_r[HOUR_W-1:0];
    assign alm_day   = bank_q.day_r[DAY_W-1:0];

    AST_DAY_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.day_r & ~DAY_KEEP) == '0); // R2

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_e == SEL_NONE) |=> $stable(bank_q)); // R2

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
#(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 7,
    parameter int DAY_W  = 3
) (
    input  logic              tick,
    input  logic              min_edge,
    input  logic [2:0]        mask_bits,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [DAY_W-1:0]  alm_day,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    output logic              fire
);

    logic        eq_min, eq_hour, eq_day;
    logic        hit;
    logic        check_slot;
    alarm_rate_e rate;

    assign eq_min     = (alm_min  == cur_min);
    assign eq_hour    = (alm_hour == cur_hour);
    assign eq_day     = (alm_day  == cur_day);
    assign check_slot = tick & min_edge;
    assign rate       = alarm_rate_e'(mask_bits);

    always_comb begin
        case (rate)
            RATE_EVERY_MIN: hit = 1'b1;
            RATE_MIN_HIT:   hit = eq_min;
            RATE_HM_HIT:    hit = eq_min & eq_hour;
            RATE_FULL_HIT:  hit = eq_min & eq_hour & eq_day;
            default:        hit = 1'b0;
        endcase
    end

    assign fire = check_slot & hit;

endmodule

// File: rtl/tod_alarm_out.sv
module tod_alarm_out #(
    parameter int PULSE_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic access,
    input  logic pulse_mode,
    input  logic tod_mask,
    input  logic src_sel,
    input  logic wdog_irq,
    output logic flag,
    output logic irq
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.flag = 1'b1;
            st_d.cnt  = LOAD;
        end else if (access) begin
            st_d.flag = 1'b0;
            st_d.cnt  = '0;
        end else if (pulse_mode && st_q.flag) begin
            if (st_q.cnt == '0) begin
                st_d.flag = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign irq  = src_sel ? wdog_irq : (st_q.flag & ~tod_mask);

    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !fire) |=> !flag); // R9

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && flag && !access) |=> flag); // R9

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && flag && st_q.cnt == '0 && !fire && !access) |=> !flag); // R10

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LOAD); // R10

endmodule

// File: rtl/tod_alarm_intr.sv
module tod_alarm_intr
    import tod_alarm_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int PULSE_MS = 3,
    parameter int MIN_W    = 7,
    parameter int HOUR_W   = 7,
    parameter int DAY_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              min_edge,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tod_mask,
    input  logic              pulse_mode,
    input  logic              src_sel,
    input  logic              wdog_irq,
    output logic              tod_flag,
    output logic              irq
);

    localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_MS;

    logic              access;
    logic              fire;
    logic [2:0]        mask_bits;
    logic [MIN_W-1:0]  alm_min;
    logic [HOUR_W-1:0] alm_hour;
    logic [DAY_W-1:0]  alm_day;

    tod_alarm_regs #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .rd_en    (reg_rd),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .access   (access),
        .mask_bits(mask_bits),
        .alm_min  (alm_min),
        .alm_hour (alm_hour),
        .alm_day  (alm_day)
    );

    tod_alarm_match #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)) u_match (
        .tick     (tick),
        .min_edge (min_edge),
        .mask_bits(mask_bits),
        .alm_min  (alm_min),
        .alm_hour (alm_hour),
        .alm_day  (alm_day),
        .cur_min  (cur_min),
        .cur_hour (cur_hour),
        .cur_day  (cur_day),
        .fire     (fire)
    );

    tod_alarm_out #(.PULSE_CYC(PULSE_CYC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .access    (access),
        .pulse_mode(pulse_mode),
        .tod_mask  (tod_mask),
        .src_sel   (src_sel),
        .wdog_irq  (wdog_irq),
        .flag      (tod_flag),
        .irq       (irq)
    );

    AST_FLAG_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tod_flag) |-> $past(tick && min_edge)); // R3

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (reg_rdata == '0)); // R2

endmodule

// File: tb/tb_tod_alarm_intr.sv
module tb_tod_alarm_intr;

    localparam int P = 30; // CLK_HZ 10000, 3 ms

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 0, min_edge = 0;
    logic [6:0] cur_min = 0, cur_hour = 0;
    logic [2:0] cur_day = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_sel = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       tod_mask = 0, pulse_mode = 0, src_sel = 0, wdog_irq = 0;
    logic       tod_flag, irq;

    int    total = 0, bad = 0;
    string cur_req = "R1";
    bit    finished = 0;

    logic [7:0] m_reg [3];
    logic       m_flag;
    int         m_cnt;

    always #5 clk = ~clk;

    tod_alarm_intr #(.CLK_HZ(10_000), .PULSE_MS(3)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .min_edge(min_edge),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tod_mask(tod_mask), .pulse_mode(pulse_mode), .src_sel(src_sel),
        .wdog_irq(wdog_irq), .tod_flag(tod_flag), .irq(irq)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    function automatic logic hit_f();
        logic em, eh, ed;
        em = (m_reg[0][6:0] == cur_min);
        eh = (m_reg[1][6:0] == cur_hour);
        ed = (m_reg[2][2:0] == cur_day);
        case ({m_reg[0][7], m_reg[1][7], m_reg[2][7]})
            3'b111:  return 1'b1;
            3'b011:  return em;
            3'b001:  return em & eh;
            3'b000:  return em & eh & ed;
            default: return 1'b0;
        endcase
    endfunction

    task automatic cyc(input logic t, input logic me, input logic wr, input logic rd,
                       input logic [1:0] sel, input logic [7:0] wd);
        logic evt, acc;
        tick = t; min_edge = me; reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
        evt = t && me && hit_f();
        acc = (wr || rd) && (sel != 2'd3);
        @(posedge clk);
        #2;
        if (evt) begin
            m_flag = 1'b1; m_cnt = P - 1;
        end else if (acc) begin
            m_flag = 1'b0; m_cnt = 0;
        end else if (pulse_mode && m_flag) begin
            if (m_cnt == 0) m_flag = 1'b0;
            else m_cnt--;
        end
        if (wr && sel != 2'd3) m_reg[sel] = (sel == 2'd2) ? (wd & 8'h87) : wd;
        chk("tod_flag", {7'd0, tod_flag}, {7'd0, m_flag});
        chk("irq", {7'd0, irq}, {7'd0, src_sel ? wdog_irq : (m_flag & ~tod_mask)});
        chk("reg_rdata", reg_rdata, (sel == 2'd3) ? 8'h00 : m_reg[sel]);
        tick = 0; min_edge = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 2'd3, 8'h00);
    endtask

    task automatic set_regs(input logic [7:0] mn, input logic [7:0] hr, input logic [7:0] dy);
        cyc(0, 0, 1, 0, 2'd0, mn);
        cyc(0, 0, 1, 0, 2'd1, hr);
        cyc(0, 0, 1, 0, 2'd2, dy);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reg[0] = 0; m_reg[1] = 0; m_reg[2] = 0; m_flag = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        cyc(0, 0, 0, 1, 2'd0, 0);
        cyc(0, 0, 0, 1, 2'd1, 0);
        cyc(0, 0, 0, 1, 2'd2, 0);

        // R2: register layout, day pad bits, unmapped select
        cur_req = "R2";
        set_regs(8'hA5, 8'h7F, 8'hFF);
        cyc(0, 0, 1, 0, 2'd3, 8'hFF);
        cyc(0, 0, 0, 1, 2'd2, 0);
        chk("day pad", reg_rdata, 8'h87);

        // R3: evaluation needs both strobes
        cur_req = "R3";
        set_regs(8'h80, 8'h80, 8'h80);
        cyc(1, 0, 0, 0, 2'd3, 0);
        cyc(0, 1, 0, 0, 2'd3, 0);
        chk("no fire w/o both strobes", {7'd0, tod_flag}, 8'h00);
        cyc(1, 1, 0, 0, 2'd3, 0);
        chk("fire on boundary", {7'd0, tod_flag}, 8'h01);
        cyc(0, 0, 0, 1, 2'd0, 0);

        // R4: every minute, any fields
        cur_req = "R4";
        cur_min = 7'h59; cur_hour = 7'h23; cur_day = 3'd6;
        cyc(1, 1, 0, 0, 2'd3, 0);
        cyc(0, 0, 0, 1, 2'd1, 0);
        cur_min = 7'h00; cyc(1, 1, 0, 0, 2'd3, 0);
        cyc(0, 0, 0, 1, 2'd1, 0);

        // R5: minute match
        cur_req = "R5";
        set_regs(8'h30, 8'h80, 8'h80);
        cur_min = 7'h31; cyc(1, 1, 0, 0, 2'd3, 0);
        cur_min = 7'h30; cyc(1, 1, 0, 0, 2'd3, 0);
        cyc(0, 0, 0, 1, 2'd0, 0);

        // R6: hours and minutes, 12-hour and PM bits included
        cur_req = "R6";
        set_regs(8'h30, 8'h52, 8'h80);
        cur_hour = 7'h72; cyc(1, 1, 0, 0, 2'd3, 0);
        cur_hour = 7'h12; cyc(1, 1, 0, 0, 2'd3, 0);
        cur_hour = 7'h52; cyc(1, 1, 0, 0, 2'd3, 0);
        cyc(0, 0, 0, 1, 2'd0, 0);

        // R7: full match
        cur_req = "R7";
        set_regs(8'h30, 8'h52, 8'h03);
        cur_day = 3'd4; cyc(1, 1, 0, 0, 2'd3, 0);
        cur_day = 3'd3; cyc(1, 1, 0, 0, 2'd3, 0);
        cyc(0, 0, 0, 1, 2'd2, 0);

        // R8: illegal mask combinations
        cur_req = "R8";
        set_regs(8'hB0, 8'h52, 8'h83);
        cyc(1, 1, 0, 0, 2'd3, 0);
        set_regs(8'hB0, 8'hD2, 8'h03);
        cyc(1, 1, 0, 0, 2'd3, 0);
        set_regs(8'h30, 8'hD2, 8'h03);
        cyc(1, 1, 0, 0, 2'd3, 0);
        chk("illegal silent", {7'd0, tod_flag}, 8'h00);

        // R9: level mode hold and clear rules
        cur_req = "R9";
        set_regs(8'h80, 8'h80, 8'h80);
        cyc(1, 1, 0, 0, 2'd3, 0);
        idle(5);
        cyc(0, 0, 0, 1, 2'd3, 0);
        cyc(0, 0, 1, 0, 2'd3, 8'h11);
        chk("sel3 keeps flag", {7'd0, tod_flag}, 8'h01);
        cyc(0, 0, 1, 0, 2'd0, 8'h80);
        chk("write clears", {7'd0, tod_flag}, 8'h00);
        cyc(1, 1, 0, 1, 2'd1, 0);
        chk("fire beats access", {7'd0, tod_flag}, 8'h01);
        cyc(0, 0, 0, 1, 2'd2, 0);

        // R10: pulse mode length and early clear
        cur_req = "R10";
        pulse_mode = 1;
        cyc(1, 1, 0, 0, 2'd3, 0);
        begin
            int hi;
            hi = 1;
            for (int i = 0; i < P + 10; i++) begin
                cyc(0, 0, 0, 0, 2'd3, 0);
                if (tod_flag) hi++;
            end
            chk("pulse length", 8'(hi), 8'(P));
        end
        cyc(1, 1, 0, 0, 2'd3, 0);
        idle(4);
        cyc(0, 0, 0, 1, 2'd0, 0);
        chk("early clear", {7'd0, tod_flag}, 8'h00);
        pulse_mode = 0;

        // R11: interrupt mask and source select
        cur_req = "R11";
        cyc(1, 1, 0, 0, 2'd3, 0);
        tod_mask = 1; idle(2);
        chk("masked irq", {7'd0, irq}, 8'h00);
        tod_mask = 0; idle(1);
        src_sel = 1; wdog_irq = 0; idle(2);
        wdog_irq = 1; idle(2);
        src_sel = 0; wdog_irq = 0;
        cyc(0, 0, 0, 1, 2'd0, 0);

        // Random mix: R4 R5 R6 R7 R8 R9 R10 R11 against the model
        cur_req = "random R4/R5/R6/R7/R8/R9/R10/R11";
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] pool [8];
            logic [2:0] k;
            pool[0] = 8'h30; pool[1] = 8'hB0; pool[2] = 8'h52; pool[3] = 8'hD2;
            pool[4] = 8'h03; pool[5] = 8'h83; pool[6] = 8'($urandom); pool[7] = 8'h80;
            if (n % 250 == 0) pulse_mode = $urandom % 2;
            if (n % 97 == 0) begin tod_mask = $urandom % 2; src_sel = ($urandom % 4) == 0; end
            wdog_irq = $urandom % 2;
            cur_min  = ($urandom % 2) ? 7'h30 : 7'h31;
            cur_hour = ($urandom % 2) ? 7'h52 : 7'h72;
            cur_day  = ($urandom % 2) ? 3'd3 : 3'd4;
            k = 3'($urandom % 8);
            cyc($urandom % 2, $urandom % 2, ($urandom % 12) == 0, ($urandom % 12) == 0,
                2'($urandom % 4), pool[k]);
        end

        summary();
    end

endmodule